// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction Unit

This block rebuilds one 4x4 tile of 8-bit pixels. A decoder hands it sixteen signed 16-bit dequantized coefficients and sixteen unsigned 8-bit prediction pixels. The block runs a separable fixed-point inverse transform over the coefficients, first down the columns and then across the rows. It rounds the result to a residual, adds that residual to the prediction and limits each sum to the 8-bit pixel range. When only the DC coefficient carries energy, the caller can raise the DC-only input. The block then skips both butterfly passes and adds a single rounded DC offset to every prediction pixel.

Both vectors are flat buses. Element k (k = 4*row + col) of the coefficient bus sits at bits [16k+15:16k], and element k of the prediction and pixel buses sits at bits [8k+7:8k]. A start pulse taken while the block is idle captures the inputs. A one-cycle done pulse marks the moment the reconstructed pixels are valid, and they hold until the next block completes. The active-low reset acts asynchronously and is released inside the block through a two-stage synchronizer.

Top module: `idct4_recon`

## Requirements
- R1: Once reset has been released and the synchronizer has settled, busy_o and done_o are 0 and pix_o is all zero.
- R2: In full mode the block uses a 1-D butterfly on each column of the coefficient block, then on each row of the intermediate block. With inputs (e0, e1, e2, e3): a = e0+e2, b = e0-e2, c = S(e1)-C(e3), d = C(e1)+S(e3). The outputs are y0 = a+d, y1 = b+c, y2 = b-c, y3 = a-d. Here S(x) = (x*35468)>>>16 and C(x) = x + ((x*20091)>>>16).
- R3: Each second-pass value v becomes the residual (v+4)>>>3, using an arithmetic shift that rounds toward negative infinity. The DC offset is (dc+4)>>>3, rounded the same way.
- R4: Each output pixel is the residual plus its prediction pixel, clamped to 0..255.
- R5: In DC-only mode every pixel is its prediction pixel plus (coef[0]+4)>>>3, and coefficients 1..15 are ignored.
- R6: In DC-only mode a large negative offset drives pixels to 0, and a large positive offset drives them to 255.
- R7: Take the cycle whose clock edge samples an accepted start as the start cycle. done_o is high two cycles after the start cycle in DC-only mode, and three cycles after it in full mode. busy_o is high from the cycle after acceptance until done_o.
- R8: A start seen while busy_o is high is ignored. The block in flight completes with its own data, and no additional done pulse follows.
- R9: done_o is high for exactly one cycle per block, and pix_o changes only in a cycle where done_o is high.
- R10: Intermediate values never wrap. Coefficients at the ends of the 16-bit range give the same result as exact integer arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a block; taken only while idle |
| dc_only_i | input | 1 | Selects the DC-only shortcut for the block being started |
| coef_i | input | 256 | Sixteen signed 16-bit coefficients, element k at [16k+15:16k] |
| pred_i | input | 128 | Sixteen unsigned 8-bit prediction pixels, element k at [8k+7:8k] |
| busy_o | output | 1 | A block is in progress |
| done_o | output | 1 | One-cycle pulse: pix_o holds the new result |
| pix_o | output | 128 | Sixteen reconstructed 8-bit pixels, element k at [8k+7:8k] |

## Verification
The bench drives negative values that are not multiples of eight, once through the DC path and once through the transform. A design that truncates toward zero instead of flooring would then return pixels one step too high. Coefficient blocks at +32767 and -32768 check the width of the intermediates. Any narrowed intermediate wraps, and the pixels then come out far from the exact model, often pinned at the wrong rail. DC offsets past both rails check saturation, where an unclamped add would wrap modulo 256. A start held high through a busy block checks that a sloppy handshake neither corrupts the result nor emits a second done.

// File: rtl/idct4_pkg.sv
`timescale 1ns/1ps
package idct4_pkg;
  localparam int COEF_W = 16;
  localparam int PIX_W  = 8;
  localparam int DIM    = 4;
  localparam int NPIX   = DIM * DIM;
  localparam int P1_W   = COEF_W + 2;
  localparam int P2_W   = P1_W + 2;
  localparam int RES_W  = P2_W - 3;
  localparam int K_W    = 18;

  // fixed-point scale factors, Q16
  localparam logic signed [K_W-1:0] K_COS_M1 = 18'sd20091;
  localparam logic signed [K_W-1:0] K_SIN    = 18'sd35468;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_P1   = 2'd1,
    ST_P2   = 2'd2
  } state_t;
endpackage

// File: rtl/idct4_butterfly.sv
`timescale 1ns/1ps
module idct4_butterfly
  import idct4_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = IN_W + 2
) (
  input  logic signed [IN_W-1:0]  x0,
  input  logic signed [IN_W-1:0]  x1,
  input  logic signed [IN_W-1:0]  x2,
  input  logic signed [IN_W-1:0]  x3,
  output logic signed [OUT_W-1:0] y0,
  output logic signed [OUT_W-1:0] y1,
  output logic signed [OUT_W-1:0] y2,
  output logic signed [OUT_W-1:0] y3
);
  localparam int PW = IN_W + K_W;

  logic signed [PW-1:0]    prod_sin1, prod_cos1, prod_sin3, prod_cos3;
  logic signed [OUT_W-1:0] sin1, cos1, sin3, cos3;
  logic signed [OUT_W-1:0] even_sum, even_dif, odd_c, odd_d;

  always_comb begin
    prod_sin1 = PW'(x1) * PW'(K_SIN);
    prod_cos1 = PW'(x1) * PW'(K_COS_M1);
    prod_sin3 = PW'(x3) * PW'(K_SIN);
    prod_cos3 = PW'(x3) * PW'(K_COS_M1);

    sin1 = OUT_W'(prod_sin1 >>> 16);
    sin3 = OUT_W'(prod_sin3 >>> 16);
    // scale above unity: x plus x times the fractional part
    cos1 = OUT_W'(x1) + OUT_W'(prod_cos1 >>> 16);
    cos3 = OUT_W'(x3) + OUT_W'(prod_cos3 >>> 16);

    even_sum = OUT_W'(x0) + OUT_W'(x2);
    even_dif = OUT_W'(x0) - OUT_W'(x2);
    odd_c    = sin1 - cos3;
    odd_d    = cos1 + sin3;

    y0 = even_sum + odd_d;
    y3 = even_sum - odd_d;
    y1 = even_dif + odd_c;
    y2 = even_dif - odd_c;
  end
endmodule

// File: rtl/idct4_pixel_add.sv
`timescale 1ns/1ps
module idct4_pixel_add #(
  parameter int RES_W = 17,
  parameter int PIX_W = 8
) (
  input  logic signed [RES_W-1:0] res,
  input  logic [PIX_W-1:0]        pred,
  output logic [PIX_W-1:0]        pix
);
  localparam int SUM_W = RES_W + 1;
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(res) + SUM_W'($signed({1'b0, pred}));
    if (sum < 0)
      pix = '0;
    else if (sum > PIX_MAX)
      pix = '1;
    else
      pix = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/idct4_ctrl.sv
`timescale 1ns/1ps
module idct4_ctrl
  import idct4_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic dc_only_i,
  output logic busy_o,
  output logic done_o,
  output logic cap_en_o,
  output logic p1_en_o,
  output logic out_en_o,
  output logic dc_sel_o
);
  state_t state_q, state_d;
  logic   dc_q, dc_d;
  logic   done_q;

  always_comb begin
    state_d  = state_q;
    cap_en_o = 1'b0;
    p1_en_o  = 1'b0;
    out_en_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en_o = 1'b1;
          state_d  = ST_P1;
        end
      end
      ST_P1: begin
        if (dc_q) begin
          out_en_o = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          p1_en_o = 1'b1;
          state_d = ST_P2;
        end
      end
      ST_P2: begin
        out_en_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    dc_d = cap_en_o ? dc_only_i : dc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dc_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dc_q    <= dc_d;
      done_q  <= out_en_o;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign dc_sel_o = dc_q;
endmodule

// File: rtl/idct4_recon.sv
`timescale 1ns/1ps
module idct4_recon
  import idct4_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    dc_only_i,
  input  logic [NPIX*COEF_W-1:0]  coef_i,
  input  logic [NPIX*PIX_W-1:0]   pred_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [NPIX*PIX_W-1:0]   pix_o
);
  localparam int DC_W = COEF_W + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic cap_en, p1_en, out_en, dc_sel;

  idct4_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .dc_only_i (dc_only_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .cap_en_o  (cap_en),
    .p1_en_o   (p1_en),
    .out_en_o  (out_en),
    .dc_sel_o  (dc_sel)
  );

  // captured operands (datapath, no reset)
  logic [NPIX-1:0][COEF_W-1:0] coef_q;
  logic [NPIX-1:0][PIX_W-1:0]  pred_q;

  always_ff @(posedge clk) begin
    if (cap_en) begin
      coef_q <= coef_i;
      pred_q <= pred_i;
    end
  end

  // first pass: columns
  logic signed [P1_W-1:0] col_d [NPIX];
  logic signed [P1_W-1:0] col_q [NPIX];

  for (genvar c = 0; c < DIM; c++) begin : g_pass1
    idct4_butterfly #(.IN_W(COEF_W), .OUT_W(P1_W)) u_bfly (
      .x0 ($signed(coef_q[c])),
      .x1 ($signed(coef_q[DIM + c])),
      .x2 ($signed(coef_q[2*DIM + c])),
      .x3 ($signed(coef_q[3*DIM + c])),
      .y0 (col_d[c]),
      .y1 (col_d[DIM + c]),
      .y2 (col_d[2*DIM + c]),
      .y3 (col_d[3*DIM + c])
    );
  end

  always_ff @(posedge clk) begin
    if (p1_en) begin
      for (int k = 0; k < NPIX; k++) col_q[k] <= col_d[k];
    end
  end

  // second pass: rows
  logic signed [P2_W-1:0]  row_d [NPIX];
  logic signed [P2_W-1:0]  row_rnd [NPIX];
  logic signed [RES_W-1:0] res_full [NPIX];

  for (genvar r = 0; r < DIM; r++) begin : g_pass2
    idct4_butterfly #(.IN_W(P1_W), .OUT_W(P2_W)) u_bfly (
      .x0 (col_q[DIM*r]),
      .x1 (col_q[DIM*r + 1]),
      .x2 (col_q[DIM*r + 2]),
      .x3 (col_q[DIM*r + 3]),
      .y0 (row_d[DIM*r]),
      .y1 (row_d[DIM*r + 1]),
      .y2 (row_d[DIM*r + 2]),
      .y3 (row_d[DIM*r + 3])
    );
  end

  for (genvar k = 0; k < NPIX; k++) begin : g_round
    assign row_rnd[k]  = row_d[k] + P2_W'(4);
    assign res_full[k] = RES_W'(row_rnd[k] >>> 3);
  end

  // DC shortcut offset
  logic signed [DC_W-1:0]  dc_rnd;
  logic signed [RES_W-1:0] res_dc;

  assign dc_rnd = DC_W'($signed(coef_q[0])) + DC_W'(4);
  assign res_dc = RES_W'(dc_rnd >>> 3);

  // reconstruction
  logic [NPIX-1:0][PIX_W-1:0] pix_d, pix_q;

  for (genvar k = 0; k < NPIX; k++) begin : g_recon
    logic signed [RES_W-1:0] res_sel;
    assign res_sel = dc_sel ? res_dc : res_full[k];

    idct4_pixel_add #(.RES_W(RES_W), .PIX_W(PIX_W)) u_add (
      .res  (res_sel),
      .pred (pred_q[k]),
      .pix  (pix_d[k])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pix_q <= '0;
    end else if (out_en) begin
      pix_q <= pix_d;
    end
  end

  assign pix_o = pix_q;
endmodule

// File: rtl/idct4_recon_chk.sv
`timescale 1ns/1ps
module idct4_recon_chk #(
  parameter int PIXBUS_W = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                dc_only_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [PIXBUS_W-1:0] pix_o
);
  // R7: DC-only block completes two cycles after acceptance
  a_r7_dc_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && dc_only_i) |-> ##2 done_o);

  // R7: full block completes three cycles after acceptance
  a_r7_full_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !dc_only_i) |-> ##3 done_o);

  // R7: busy rises after an accepted start
  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R8: completion leaves the block idle, ready for the next start
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: pixels hold except in a done cycle
  a_r9_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(pix_o));
endmodule

bind idct4_recon idct4_recon_chk #(.PIXBUS_W(128)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start_i   (start_i),
  .dc_only_i (dc_only_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .pix_o     (pix_o)
);

// File: tb/idct4_recon_bench.sv
`timescale 1ns/1ps
module idct4_recon_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic         dc_only_i;
  logic [255:0] coef_i;
  logic [127:0] pred_i;
  logic         busy_o;
  logic         done_o;
  logic [127:0] pix_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  idct4_recon u_idct4_recon (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .dc_only_i (dc_only_i),
    .coef_i    (coef_i),
    .pred_i    (pred_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pix_o     (pix_o)
  );

  typedef struct packed {
    logic               dc;
    logic signed [15:0] base;
    logic signed [15:0] step;
    logic [7:0]         pbase;
    logic [7:0]         pstep;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'sd0,      16'sd0,    8'd10,  8'd7},   // zero residual
    '{1'b0, 16'sd100,    16'sd37,   8'd128, 8'd3},   // R2 mixed signs
    '{1'b0, -16'sd500,   16'sd60,   8'd200, 8'd5},   // R3 negative values
    '{1'b0, 16'sd3000,   -16'sd211, 8'd20,  8'd13},  // R4 clamp both ends
    '{1'b1, 16'sd77,     16'sd0,    8'd250, 8'd1},   // R5 DC, top rail
    '{1'b1, -16'sd300,   16'sd9,    8'd5,   8'd17},  // R6 DC, bottom rail
    '{1'b0, 16'sd32767,  16'sd0,    8'd128, 8'd0},   // R10 positive extreme
    '{1'b0, -16'sd32768, 16'sd0,    8'd128, 8'd0}    // R10 negative extreme
  };

  function automatic longint f_sin(longint x);
    return (x * 35468) >>> 16;
  endfunction

  function automatic longint f_cos(longint x);
    return x + ((x * 20091) >>> 16);
  endfunction

  function automatic logic [127:0] model(logic dc, logic [255:0] c, logic [127:0] p);
    longint x [16];
    longint t [16];
    longint u [16];
    longint res, a, b, cc, d, v;
    logic [127:0] o;
    for (int k = 0; k < 16; k++) x[k] = longint'($signed(c[16*k +: 16]));
    for (int col = 0; col < 4; col++) begin
      a  = x[col] + x[8+col];
      b  = x[col] - x[8+col];
      cc = f_sin(x[4+col]) - f_cos(x[12+col]);
      d  = f_cos(x[4+col]) + f_sin(x[12+col]);
      t[col]    = a + d;
      t[12+col] = a - d;
      t[4+col]  = b + cc;
      t[8+col]  = b - cc;
    end
    for (int r = 0; r < 4; r++) begin
      a  = t[4*r] + t[4*r+2];
      b  = t[4*r] - t[4*r+2];
      cc = f_sin(t[4*r+1]) - f_cos(t[4*r+3]);
      d  = f_cos(t[4*r+1]) + f_sin(t[4*r+3]);
      u[4*r]   = a + d;
      u[4*r+3] = a - d;
      u[4*r+1] = b + cc;
      u[4*r+2] = b - cc;
    end
    for (int k = 0; k < 16; k++) begin
      res = dc ? ((x[0] + 4) >>> 3) : ((u[k] + 4) >>> 3);
      v = res + longint'(p[8*k +: 8]);
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      o[8*k +: 8] = v[7:0];
    end
    return o;
  endfunction

  task automatic check_val(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_pix(string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // drive one block; returns pixels seen in the done cycle
  task automatic run_block(input logic dc, input logic [255:0] c,
                           input logic [127:0] p, input string tag,
                           output logic [127:0] got);
    int n;
    @(negedge clk);
    coef_i = c; pred_i = p; dc_only_i = dc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    while (!done_o && n < 10) begin
      @(negedge clk);
      n++;
    end
    check_val({tag, " R7 latency"}, n, dc ? 2 : 3);
    got = pix_o;
  endtask

  function automatic logic [255:0] one_coef(int idx, int val);
    logic [255:0] c = '0;
    c[16*idx +: 16] = val[15:0];
    return c;
  endfunction

  function automatic logic [127:0] flat_pred(int val);
    logic [127:0] p;
    for (int k = 0; k < 16; k++) p[8*k +: 8] = val[7:0];
    return p;
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] got, exp, held;
    logic [255:0] c;
    logic [127:0] p;
    int v;

    rst_n = 1'b0; start_i = 1'b0; dc_only_i = 1'b0; coef_i = '0; pred_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_val("R1 busy", busy_o, 0);
    check_val("R1 done", done_o, 0);
    check_pix("R1 pix", pix_o, '0);

    // table of stimulus vectors
    for (int i = 0; i < NVEC; i++) begin
      for (int k = 0; k < 16; k++) begin
        v = int'(VECS[i].base) + int'(VECS[i].step) * k;
        if (k % 2 == 1) v = -v;
        c[16*k +: 16] = v[15:0];
        v = int'(VECS[i].pbase) + int'(VECS[i].pstep) * k;
        p[8*k +: 8] = v[7:0];
      end
      run_block(VECS[i].dc, c, p, $sformatf("vec%0d", i), got);
      check_pix($sformatf("vec%0d R2 R4 R5 R6 R10", i), got, model(VECS[i].dc, c, p));
    end

    // R2: lone odd coefficient, hand-derived row pattern 144,135,121,112
    run_block(1'b0, one_coef(1, 100), flat_pred(128), "R2 hand", got);
    for (int r = 0; r < 4; r++) begin
      exp[32*r +: 32] = {8'd112, 8'd121, 8'd135, 8'd144};
    end
    check_pix("R2 hand pattern", got, exp);

    // R3: floor rounding of a negative DC through the transform: 16 -> 15
    run_block(1'b0, one_coef(0, -9), flat_pred(16), "R3 full", got);
    check_pix("R3 full-mode floor", got, flat_pred(15));

    // R3 and R5: same DC through the shortcut, other coefficients ignored
    c = one_coef(0, -9) | one_coef(5, 1234) | one_coef(15, -777);
    run_block(1'b1, c, flat_pred(16), "R5 dc", got);
    check_pix("R3 R5 dc-mode floor, ac ignored", got, flat_pred(15));

    // R6: saturation at both rails
    run_block(1'b1, one_coef(0, 32767), flat_pred(3), "R6 hi", got);
    check_pix("R6 dc top rail", got, flat_pred(255));
    run_block(1'b1, one_coef(0, -32768), flat_pred(250), "R6 lo", got);
    check_pix("R6 dc bottom rail", got, flat_pred(0));

    // R8: start held high while busy is ignored
    @(negedge clk);
    coef_i = one_coef(1, 100); pred_i = flat_pred(128); dc_only_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    check_val("R7 busy after accept", busy_o, 1);
    coef_i = one_coef(0, 32767); pred_i = flat_pred(0); dc_only_i = 1'b1;
    @(negedge clk);
    check_val("R8 still busy", busy_o, 1);
    check_val("R8 no early done", done_o, 0);
    @(negedge clk);
    start_i = 1'b0;
    check_val("R8 done for first block", done_o, 1);
    check_pix("R8 first block data kept", pix_o, exp);

    // R9: single-cycle done, pixels held afterwards
    held = pix_o;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      check_val("R8 R9 no extra done", done_o, 0);
    end
    check_pix("R9 pix held", pix_o, held);
    check_val("R9 idle after done", busy_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule